// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block drives the memory side of a block load or block store of general registers in a small sequential 32-bit processor. The decoder hands it one instruction: a 16-bit register mask, a load/store select, a pre/post select, an up/down select, a writeback enable, a privileged-transfer flag, the index of the base register, and the base register's current value. The block then steps through the selected registers one word at a time over a request/acknowledge memory port. For each word it presents the byte address, the register index the word belongs to, and whether the access is a write to memory.

The block counts the set bits of the mask up front and uses that count to find the lowest address of the block. Registers therefore always occupy ascending addresses in ascending index order, whichever direction was encoded. When the last word is acknowledged, the block raises a one-cycle completion pulse together with the base writeback decision. A base register that is loaded from memory in the same instruction wins over the arithmetic writeback value. Because the writeback is reported only at the end, the base register can never be overwritten partway through the sequence.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the block is idle (`idle`=1), with `mem_req`=0, `done`=0 and `wb_en`=0.
- R2: A start accepted while idle produces exactly N memory requests, where N is the number of set bits in `cmd_mask`. The requests name each selected register once, in strictly ascending index order, so register 15 is always the last.
- R3: Transfer addresses rise by 4 from one request to the next. With N set bits and base B, the first address depends on {`cmd_pre`,`cmd_up`}: {1,1} gives B+4, {0,1} gives B, {1,0} gives B-4N, and {0,0} gives B-4N+4.
- R4: `mem_write` is 1 on every request of a store (`cmd_load`=0) and 0 on every request of a load (`cmd_load`=1).
- R5: `done` pulses for one cycle in the cycle after the final acknowledge. `wb_en` may be 1 only during `done`. With `cmd_wb`=1, `wb_data` is B+4N when `cmd_up`=1 and B-4N when `cmd_up`=0, and `wb_reg` equals `cmd_base`. With `cmd_wb`=0, `wb_en` stays 0.
- R6: For a load whose mask includes the base register, `wb_en` stays 0 even when `cmd_wb`=1, so the loaded word is the base's final value. For a store whose mask includes the base register, the writeback is reported as in R5.
- R7: An all-zero mask makes no memory request. `done` rises in the cycle after the start, and when `cmd_wb`=1 it reports a writeback of the unchanged base.
- R8: While a request is not acknowledged, `mem_req`, `mem_addr` and `mem_reg` hold their values.
- R9: `start` is ignored unless `idle` is 1, so command inputs that change during a sequence have no effect on it. `cmd_priv` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the command inputs (taken only when idle) |
| cmd_mask | input | 16 | Register selection mask, bit i selects register i |
| cmd_load | input | 1 | 1 = load from memory, 0 = store to memory |
| cmd_pre | input | 1 | 1 = step address before the transfer, 0 = after |
| cmd_up | input | 1 | 1 = ascending base update, 0 = descending |
| cmd_wb | input | 1 | Write the updated base back |
| cmd_priv | input | 1 | Privileged-transfer flag, accepted and ignored |
| cmd_base | input | 4 | Index of the base register |
| base_val | input | 32 | Current base register value |
| idle | output | 1 | Ready for a new command |
| mem_req | output | 1 | Memory transfer request |
| mem_ack | input | 1 | Memory acknowledge; completes the current transfer |
| mem_addr | output | 32 | Byte address of the current transfer |
| mem_reg | output | 4 | Register index of the current transfer |
| mem_write | output | 1 | 1 = store to memory, 0 = load from memory |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Base writeback valid (only with done) |
| wb_reg | output | 4 | Base register index to write back |
| wb_data | output | 32 | Base writeback value |

## Verification
The bench targets the cases where a sequencer of this kind typically goes wrong. In the two descending modes, a start address that ignores the population count puts registers at mirrored addresses. A load that lists its own base needs the writeback suppressed; without that, the arithmetic value overwrites the loaded word. Stores that list the base must still write back. An empty mask must finish without touching memory, and a full mask with register 15 must place that register last. Random acknowledge stalls and a start raised mid-sequence expose a sequencer that drifts its address or restarts while busy.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        BX_IDLE = 2'd0,
        BX_BUSY = 2'd1,
        BX_FIN  = 2'd2
    } bx_state_e;

    // Addressing mode, encoded as {pre, up}
    typedef enum logic [1:0] {
        BX_DEC_AFTER  = 2'b00,
        BX_INC_AFTER  = 2'b01,
        BX_DEC_BEFORE = 2'b10,
        BX_INC_BEFORE = 2'b11
    } bx_mode_e;

    function automatic bx_mode_e bx_mode(input logic pre, input logic up);
        return bx_mode_e'({pre, up});
    endfunction

endpackage

// File: rtl/blkxfer_popcount.sv
module blkxfer_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] partial [N+1];

    assign partial[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_acc
        assign partial[i+1] = partial[i] + CW'(vec[i]);
    end
    assign count = partial[N];
endmodule

// File: rtl/blkxfer_lowest.sv
module blkxfer_lowest #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [N-1:0]  sel,
    output logic [IW-1:0] idx
);
    assign sel = mask & (~mask + N'(1));

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan
    import blkxfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 5,
    parameter int WB = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          pre,
    input  logic          up,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam logic [AW-1:0] STEP = AW'(WB);

    logic [AW-1:0] span;
    assign span = AW'(count) * STEP;

    always_comb begin
        unique case (bx_mode(pre, up))
            BX_INC_BEFORE: first_addr = base + STEP;
            BX_INC_AFTER:  first_addr = base;
            BX_DEC_BEFORE: first_addr = base - span;
            default:       first_addr = base - span + STEP;
        endcase
        final_base = up ? (base + span) : (base - span);
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NREG  = 16,
    parameter int WB    = 4,
    parameter int IDXW  = $clog2(NREG),
    parameter int CNTW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NREG-1:0] cmd_mask,
    input  logic            cmd_load,
    input  logic            cmd_pre,
    input  logic            cmd_up,
    input  logic            cmd_wb,
    input  logic            cmd_priv,
    input  logic [IDXW-1:0] cmd_base,
    input  logic [AW-1:0]   base_val,
    output logic            idle,
    output logic            mem_req,
    input  logic            mem_ack,
    output logic [AW-1:0]   mem_addr,
    output logic [IDXW-1:0] mem_reg,
    output logic            mem_write,
    output logic            done,
    output logic            wb_en,
    output logic [IDXW-1:0] wb_reg,
    output logic [AW-1:0]   wb_data
);
    localparam logic [AW-1:0] STEP = AW'(WB);

    bx_state_e       state;
    logic [NREG-1:0] remain;
    logic [AW-1:0]   cur_addr;
    logic [AW-1:0]   wb_val_q;
    logic            wb_ok_q;
    logic            load_q;
    logic [IDXW-1:0] base_q;

    logic [CNTW-1:0] n_sel;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [NREG-1:0] cur_sel;
    logic [IDXW-1:0] cur_idx;
    logic [NREG-1:0] remain_nx;
    logic            unused_priv;

    assign unused_priv = cmd_priv;

    blkxfer_popcount #(.N(NREG), .CW(CNTW)) u_count (
        .vec   (cmd_mask),
        .count (n_sel)
    );

    blkxfer_addr_plan #(.AW(AW), .CW(CNTW), .WB(WB)) u_plan (
        .base       (base_val),
        .count      (n_sel),
        .pre        (cmd_pre),
        .up         (cmd_up),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    blkxfer_lowest #(.N(NREG), .IW(IDXW)) u_pick (
        .mask (remain),
        .sel  (cur_sel),
        .idx  (cur_idx)
    );

    assign remain_nx = remain & ~cur_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BX_IDLE;
            remain   <= '0;
            cur_addr <= '0;
            wb_val_q <= '0;
            wb_ok_q  <= 1'b0;
            load_q   <= 1'b0;
            base_q   <= '0;
        end else begin
            unique case (state)
                BX_IDLE: begin
                    if (start) begin
                        remain   <= cmd_mask;
                        cur_addr <= first_addr;
                        wb_val_q <= final_base;
                        // a loaded base outranks the arithmetic writeback
                        wb_ok_q  <= cmd_wb && !(cmd_load && cmd_mask[cmd_base]);
                        load_q   <= cmd_load;
                        base_q   <= cmd_base;
                        state    <= (cmd_mask == '0) ? BX_FIN : BX_BUSY;
                    end
                end
                BX_BUSY: begin
                    if (mem_ack) begin
                        remain   <= remain_nx;
                        cur_addr <= cur_addr + STEP;
                        if (remain_nx == '0) state <= BX_FIN;
                    end
                end
                default: state <= BX_IDLE;
            endcase
        end
    end

    assign idle      = (state == BX_IDLE);
    assign mem_req   = (state == BX_BUSY);
    assign mem_addr  = cur_addr;
    assign mem_reg   = cur_idx;
    assign mem_write = !load_q;
    assign done      = (state == BX_FIN);
    assign wb_en     = done && wb_ok_q;
    assign wb_reg    = base_q;
    assign wb_data   = wb_val_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mem_req && !done)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + STEP)); // R3

    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_reg > $past(mem_reg))); // R2

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || $stable(mem_write))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done); // R5

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg))); // R8

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && start) |=> (mem_req && $stable(mem_addr))); // R9
endmodule

// File: tb/tb_blkxfer_seq.sv
module tb_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] cmd_mask;
    logic        cmd_load, cmd_pre, cmd_up, cmd_wb, cmd_priv;
    logic [3:0]  cmd_base;
    logic [31:0] base_val;
    logic        idle, mem_req, mem_ack, mem_write, done, wb_en;
    logic [31:0] mem_addr, wb_data;
    logic [3:0]  mem_reg, wb_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    blkxfer_seq dut (
        .clk(clk), .rst(rst), .start(start), .cmd_mask(cmd_mask),
        .cmd_load(cmd_load), .cmd_pre(cmd_pre), .cmd_up(cmd_up),
        .cmd_wb(cmd_wb), .cmd_priv(cmd_priv), .cmd_base(cmd_base),
        .base_val(base_val), .idle(idle), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_reg(mem_reg),
        .mem_write(mem_write), .done(done), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int pop16(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] low_addr(input logic [31:0] b, input int n,
                                             input bit p, input bit u);
        logic [31:0] sp = 32'(n) * 32'd4;
        if (p && u)  return b + 32'd4;
        if (!p && u) return b;
        if (p && !u) return b - sp;
        return b - sp + 32'd4;
    endfunction

    task automatic run(input logic [15:0] m, input bit l, input bit p, input bit u,
                       input bit w, input bit s, input logic [3:0] bi,
                       input logic [31:0] b, input bit poke);
        int n = pop16(m);
        logic [31:0] a0 = low_addr(b, n, p, u);
        logic [31:0] wbv = u ? b + 32'(n) * 32'd4 : b - 32'(n) * 32'd4;
        bit wbe = w && !(l && m[bi]);
        logic [3:0] order [16];
        int k = 0;
        int cyc = 0;
        bit fin = 0;
        int j = 0;
        for (int i = 0; i < 16; i++) if (m[i]) begin order[j] = 4'(i); j++; end
        @(negedge clk);
        chk(idle === 1'b1, "R9", "idle before start", 32'(idle), 32'd1);
        cmd_mask = m; cmd_load = l; cmd_pre = p; cmd_up = u; cmd_wb = w;
        cmd_priv = s; cmd_base = bi; base_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 400) begin
            bit acked = 0;
            if (done) begin
                chk(k == n, "R2", "request count", 32'(k), 32'(n));
                chk(mem_req === 1'b0, "R5", "req during done", 32'(mem_req), 32'd0);
                chk(wb_en === wbe, (l && m[bi]) ? "R6" : "R5", "wb_en", 32'(wb_en), 32'(wbe));
                if (wbe) begin
                    chk(wb_data === wbv, "R5", "wb_data", wb_data, wbv);
                    chk(wb_reg === bi, "R5", "wb_reg", 32'(wb_reg), 32'(bi));
                end
                fin = 1;
            end else if (mem_req) begin
                chk(k < n, "R2", "extra request", 32'(k), 32'(n));
                if (k < n) begin
                    chk(mem_addr === a0 + 32'(k) * 32'd4, "R3", "address", mem_addr,
                        a0 + 32'(k) * 32'd4);
                    chk(mem_reg === order[k], "R2", "register order", 32'(mem_reg),
                        32'(order[k]));
                end
                chk(mem_write === !l, "R4", "direction", 32'(mem_write), 32'(!l));
                if (poke && cyc == 0) begin
                    start = 1'b1; cmd_mask = ~m; cmd_up = ~u; base_val = ~b;
                end
                acked = ($urandom % 3) != 0;
                mem_ack = acked;
            end else begin
                chk(0, "R7", "neither request nor done", 32'(idle), 32'd0);
            end
            @(negedge clk);
            start = 1'b0;
            mem_ack = 1'b0;
            if (acked) k++;
            cyc++;
        end
        chk(fin, "R5", "sequence completed", 32'(fin), 32'd1);
        chk(done === 1'b0 && idle === 1'b1, "R5", "done is one pulse", 32'(done), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected <150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; start = 1'b0; mem_ack = 1'b0; cmd_mask = '0; cmd_load = 0;
        cmd_pre = 0; cmd_up = 0; cmd_wb = 0; cmd_priv = 0; cmd_base = '0; base_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(idle === 1'b1, "R1", "idle", 32'(idle), 32'd1);
        chk(mem_req === 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
        chk(done === 1'b0 && wb_en === 1'b0, "R1", "done/wb_en", 32'(done), 32'd0);
        // R7 empty mask, with and without writeback
        run(16'h0000, 1, 1, 1, 1, 0, 4'd3, 32'h0000_1000, 0);
        run(16'h0000, 0, 0, 0, 0, 0, 4'd3, 32'h0000_1000, 0);
        // R3 all four modes, full mask, R15 last (R2)
        for (int md = 0; md < 4; md++)
            run(16'hFFFF, md[0], md[1], md[0], 1, 0, 4'd13, 32'h0000_8000, 0);
        // R6 load lists its base: writeback suppressed; store lists base: kept
        run(16'h0421, 1, 0, 1, 1, 0, 4'd5, 32'h0000_2000, 0);
        run(16'h0421, 0, 1, 0, 1, 0, 4'd5, 32'h0000_2000, 0);
        // single R15, descending after
        run(16'h8000, 1, 0, 0, 1, 0, 4'd1, 32'h0000_0400, 0);
        // R9 start while busy ignored, S flag set
        run(16'h30C2, 0, 1, 1, 1, 1, 4'd9, 32'h0001_0000, 1);
        run(16'h30C2, 0, 1, 1, 1, 0, 4'd9, 32'h0001_0000, 0);
        // random mix
        for (int t = 0; t < 60; t++) begin
            logic [31:0] r = $urandom;
            run(16'($urandom), r[0], r[1], r[2], r[3], r[4], r[8:5],
                {16'h0, 16'($urandom)} & 32'hFFFF_FFFC, r[9]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule